// File: doc/BRIEF.md
# Integer Arithmetic and Logic Unit

This block is the arithmetic and logic stage of a small integer core. It takes two operands and a 4-bit operation select and returns one result word from the same inputs, with no register in the path. It covers wrapping add and subtract, bitwise AND, OR and XOR, signed and unsigned less-than tests, three kinds of shift, and a pass-through of the second operand. Select codes that name no operation give a zero result.

The data width is a parameter and defaults to 32. The shift amount is taken only from the low log2(WIDTH) bits of B, which are B[4:0] at the default width. A single subtractor serves SUB and both compares. A single right shifter serves all three shifts: a left shift is done by reversing the bits before and after it.

Top module: `int_alu`

## Requirements
- R1: Select 4'd0 (add) outputs (A + B) modulo 2^WIDTH. The carry out is dropped.
- R2: Select 4'd1 (subtract) outputs (A - B) modulo 2^WIDTH.
- R3: Select 4'd2 outputs A AND B, 4'd3 outputs A OR B and 4'd4 outputs A XOR B, each bit by bit.
- R4: Select 4'd5 (signed less-than) treats A and B as two's-complement values. It outputs 1 in bit 0 when A < B and 0 otherwise, and all higher bits are 0.
- R5: Select 4'd6 (unsigned less-than) treats A and B as unsigned values. It outputs 1 in bit 0 when A < B and 0 otherwise, and all higher bits are 0.
- R6: Select 4'd7 shifts A left and select 4'd9 shifts A right, both logically and filling vacated bits with 0. The amount is B[log2(WIDTH)-1:0].
- R7: Select 4'd8 shifts A right arithmetically by B[log2(WIDTH)-1:0] and fills vacated bits with A's top bit.
- R8: Bits of B above the shift-amount field have no effect on any shift result.
- R9: Select 4'd10 outputs B unchanged.
- R10: Select codes 4'd11 to 4'd15 output all zeros for any A and B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 4 | Operation select, encoded as in the requirements |
| a_i | input | WIDTH | First operand; the value that is shifted |
| b_i | input | WIDTH | Second operand; its low bits give the shift amount |
| result_o | output | WIDTH | Result of the selected operation |

## Verification
Every result is due in the same cycle as its inputs, because no register lies between the operands and result_o. The bench changes the inputs shortly after a rising clock edge and reads result_o one nanosecond later. This is well before the next edge, so each check sees only settled logic driven by the current vector. An 8-bit copy is swept over every A value, sixteen B patterns and all sixteen select codes. The 32-bit instance gets directed corner values, such as carries that wrap, sign boundaries, a shift by the maximum amount, and high B bits set during shifts.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;

    localparam int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_ADD   = 4'd0,
        OP_SUB   = 4'd1,
        OP_AND   = 4'd2,
        OP_OR    = 4'd3,
        OP_XOR   = 4'd4,
        OP_SLT   = 4'd5,
        OP_SLTU  = 4'd6,
        OP_SLL   = 4'd7,
        OP_SRA   = 4'd8,
        OP_SRL   = 4'd9,
        OP_PASSB = 4'd10
    } alu_op_e;

    typedef struct packed {
        logic sub;      // adder runs as A - B
        logic sh_left;  // shifter mirrors its data
        logic sh_arith; // shifter fills with the sign
    } alu_ctrl_t;

    function automatic alu_ctrl_t decode_op(input alu_op_e op);
        alu_ctrl_t c;
        c.sub      = (op == OP_SUB) || (op == OP_SLT) || (op == OP_SLTU);
        c.sh_left  = (op == OP_SLL);
        c.sh_arith = (op == OP_SRA);
        return c;
    endfunction

endpackage

// File: rtl/int_alu_addsub.sv
module int_alu_addsub #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             sub_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             ult_o,
    output logic             slt_o
);
    localparam int EW = WIDTH + 1;

    logic [EW-1:0] wide;

    always_comb begin
        wide  = {1'b0, a_i} + {1'b0, b_i ^ {WIDTH{sub_i}}} + EW'(sub_i);
        sum_o = wide[WIDTH-1:0];
        // meaningful only while sub_i is set: no borrow means a >= b
        ult_o = ~wide[WIDTH];
        slt_o = (a_i[WIDTH-1] ^ b_i[WIDTH-1]) ? a_i[WIDTH-1] : wide[WIDTH-1];
    end
endmodule

// File: rtl/int_alu_logic.sv
module int_alu_logic #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic [WIDTH-1:0] and_o,
    output logic [WIDTH-1:0] or_o,
    output logic [WIDTH-1:0] xor_o
);
    always_comb begin
        and_o = a_i & b_i;
        or_o  = a_i | b_i;
        xor_o = a_i ^ b_i;
    end
endmodule

// File: rtl/int_alu_shift.sv
module int_alu_shift #(
    parameter int WIDTH = 32,
    parameter int SW    = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] val_i,
    input  logic [SW-1:0]    amt_i,
    input  logic             left_i,
    input  logic             arith_i,
    output logic [WIDTH-1:0] res_o
);
    logic [WIDTH-1:0]       mirrored_in;
    logic [WIDTH-1:0]       mirrored_out;
    logic [SW:0][WIDTH-1:0] stage;
    logic                   fill;

    // bit reversal lets one right shifter serve the left shift too
    for (genvar i = 0; i < WIDTH; i++) begin : g_mirror
        assign mirrored_in[i]  = val_i[WIDTH-1-i];
        assign mirrored_out[i] = stage[SW][WIDTH-1-i];
    end

    assign fill     = arith_i & val_i[WIDTH-1];
    assign stage[0] = left_i ? mirrored_in : val_i;

    for (genvar k = 0; k < SW; k++) begin : g_stage
        localparam int D = 1 << k;
        assign stage[k+1] = amt_i[k] ? {{D{fill}}, stage[k][WIDTH-1:D]} : stage[k];
    end

    assign res_o = left_i ? mirrored_out : stage[SW];
endmodule

// File: rtl/int_alu.sv
module int_alu
    import int_alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [OP_W-1:0]  op_i,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic [WIDTH-1:0] result_o
);
    localparam int SW = $clog2(WIDTH);

    alu_op_e          op;
    alu_ctrl_t        ctrl;
    logic [WIDTH-1:0] sum, and_r, or_r, xor_r, shifted;
    logic             ult, slt;
    logic [SW-1:0]    shamt;

    assign op    = alu_op_e'(op_i);
    assign ctrl  = decode_op(op);
    assign shamt = b_i[SW-1:0];

    int_alu_addsub #(.WIDTH(WIDTH)) u_addsub (
        .a_i(a_i), .b_i(b_i), .sub_i(ctrl.sub),
        .sum_o(sum), .ult_o(ult), .slt_o(slt)
    );

    int_alu_logic #(.WIDTH(WIDTH)) u_logic (
        .a_i(a_i), .b_i(b_i), .and_o(and_r), .or_o(or_r), .xor_o(xor_r)
    );

    int_alu_shift #(.WIDTH(WIDTH), .SW(SW)) u_shift (
        .val_i(a_i), .amt_i(shamt), .left_i(ctrl.sh_left),
        .arith_i(ctrl.sh_arith), .res_o(shifted)
    );

    always_comb begin
        case (op)
            OP_ADD, OP_SUB:          result_o = sum;
            OP_AND:                  result_o = and_r;
            OP_OR:                   result_o = or_r;
            OP_XOR:                  result_o = xor_r;
            OP_SLT:                  result_o = WIDTH'(slt);
            OP_SLTU:                 result_o = WIDTH'(ult);
            OP_SLL, OP_SRA, OP_SRL:  result_o = shifted;
            OP_PASSB:                result_o = b_i;
            default:                 result_o = '0;
        endcase
    end

    always_comb begin
        if (!$isunknown({op_i, a_i, b_i})) begin
            if (op == OP_SUB)
                assert_sub_inverse_R2: assert ((result_o + b_i) == a_i)
                    else $error("subtract result plus B differs from A");
            if (op == OP_SLT || op == OP_SLTU) // R4 and R5
                assert_setlt_zext_R4: assert (result_o[WIDTH-1:1] == '0)
                    else $error("compare result has upper bits set");
            if (op == OP_SLL)
                assert_sll_lowzero_R6: assert ((result_o & ((WIDTH'(1) << shamt) - WIDTH'(1))) == '0)
                    else $error("left shift left nonzero low bits");
            if (op == OP_SRA && a_i[WIDTH-1])
                assert_sra_sign_R7: assert (result_o[WIDTH-1])
                    else $error("arithmetic shift lost the sign");
            if (op == OP_PASSB)
                assert_passb_R9: assert (result_o == b_i)
                    else $error("pass-through altered B");
            if (op_i > 4'd10)
                assert_undef_zero_R10: assert (result_o == '0)
                    else $error("undefined select gave nonzero result");
        end
    end
endmodule

// File: tb/int_alu_bench.sv
module int_alu_bench;
    localparam int W  = 32;
    localparam int WS = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk; // 250 MHz

    logic [3:0]    op32, op8;
    logic [W-1:0]  a32, b32, r32;
    logic [WS-1:0] a8, b8, r8;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    int_alu #(.WIDTH(W)) u_int_alu (
        .op_i(op32), .a_i(a32), .b_i(b32), .result_o(r32)
    );

    int_alu #(.WIDTH(WS)) u_int_alu_w8 (
        .op_i(op8), .a_i(a8), .b_i(b8), .result_o(r8)
    );

    function automatic string tag_of(input logic [3:0] op);
        case (op)
            4'd0: return "R1";
            4'd1: return "R2";
            4'd2, 4'd3, 4'd4: return "R3";
            4'd5: return "R4";
            4'd6: return "R5";
            4'd7, 4'd9: return "R6";
            4'd8: return "R7";
            4'd10: return "R9";
            default: return "R10";
        endcase
    endfunction

    // reference computed from the requirements, for widths up to 32
    function automatic logic [31:0] model(input int w, input logic [3:0] op,
                                          input logic [31:0] ai, input logic [31:0] bi);
        logic [31:0] mask, a, b, sa, sb;
        int sh;
        mask = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
        a  = ai & mask;
        b  = bi & mask;
        sh = int'(b) % w;
        sa = a[w-1] ? (a | ~mask) : a;
        sb = b[w-1] ? (b | ~mask) : b;
        case (op)
            4'd0:  return (a + b) & mask;
            4'd1:  return (a - b) & mask;
            4'd2:  return a & b;
            4'd3:  return a | b;
            4'd4:  return a ^ b;
            4'd5:  return ($signed(sa) < $signed(sb)) ? 32'd1 : 32'd0;
            4'd6:  return (a < b) ? 32'd1 : 32'd0;
            4'd7:  return (a << sh) & mask;
            4'd8:  return ($signed(sa) >>> sh) & mask;
            4'd9:  return a >> sh;
            4'd10: return b;
            default: return 32'd0;
        endcase
    endfunction

    task automatic check32(input logic [3:0] op, input logic [W-1:0] a,
                           input logic [W-1:0] b, input logic [W-1:0] exp,
                           input string tag);
        @(posedge clk);
        #1;
        op32 = op; a32 = a; b32 = b;
        #1;
        total++;
        if (r32 !== exp) begin
            bad++;
            $display("FAIL %s op=%0d a=%h b=%h actual=%h expected=%h",
                     tag, op, a, b, r32, exp);
        end
    endtask

    task automatic check8(input logic [3:0] op, input logic [WS-1:0] a,
                          input logic [WS-1:0] b);
        logic [WS-1:0] exp;
        exp = WS'(model(WS, op, 32'(a), 32'(b)));
        @(posedge clk);
        #1;
        op8 = op; a8 = a; b8 = b;
        #1;
        total++;
        if (r8 !== exp) begin
            bad++;
            $display("FAIL %s (w8) op=%0d a=%h b=%h actual=%h expected=%h",
                     tag_of(op), op, a, b, r8, exp);
        end
    endtask

    initial begin
        op32 = '0; a32 = '0; b32 = '0;
        op8  = '0; a8  = '0; b8  = '0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // idle state: zero operands under add give zero (R1)
        check32(4'd0, 32'h0, 32'h0, 32'h0, "R1");

        // R1 wrap and plain sum
        check32(4'd0, 32'hFFFF_FFFF, 32'h1, 32'h0, "R1");
        check32(4'd0, 32'h1234_5678, 32'h1111_1111, 32'h2345_6789, "R1");
        // R2 borrow wrap and ordinary difference
        check32(4'd1, 32'h0, 32'h1, 32'hFFFF_FFFF, "R2");
        check32(4'd1, 32'h8000_0000, 32'h1, 32'h7FFF_FFFF, "R2");
        // R3 bitwise ops
        check32(4'd2, 32'hF0F0_1234, 32'hFF00_FF00, 32'hF000_1200, "R3");
        check32(4'd3, 32'hF0F0_1234, 32'hFF00_FF00, 32'hFFF0_FF34, "R3");
        check32(4'd4, 32'hF0F0_1234, 32'hFF00_FF00, 32'h0FF0_ED34, "R3");
        // R4 signed compare across the sign boundary
        check32(4'd5, 32'h8000_0000, 32'h1, 32'h1, "R4");
        check32(4'd5, 32'h1, 32'h8000_0000, 32'h0, "R4");
        check32(4'd5, 32'hFFFF_FFFE, 32'hFFFF_FFFF, 32'h1, "R4");
        check32(4'd5, 32'h5, 32'h5, 32'h0, "R4");
        // R5 unsigned compare on the same patterns
        check32(4'd6, 32'h8000_0000, 32'h1, 32'h0, "R5");
        check32(4'd6, 32'h1, 32'h8000_0000, 32'h1, "R5");
        check32(4'd6, 32'h7, 32'h7, 32'h0, "R5");
        // R6 logical shifts, maximum amount
        check32(4'd7, 32'h0000_0001, 32'd31, 32'h8000_0000, "R6");
        check32(4'd9, 32'h8000_0000, 32'd31, 32'h0000_0001, "R6");
        check32(4'd9, 32'hF000_000F, 32'd4, 32'h0F00_0000, "R6");
        // R7 arithmetic right shift, negative and positive
        check32(4'd8, 32'h8000_0000, 32'd31, 32'hFFFF_FFFF, "R7");
        check32(4'd8, 32'h7000_0000, 32'd4, 32'h0700_0000, "R7");
        check32(4'd8, 32'hF000_0010, 32'd4, 32'hFF00_0001, "R7");
        // R8 high B bits ignored by shifts
        check32(4'd7, 32'h0000_00FF, 32'h0000_0020, 32'h0000_00FF, "R8");
        check32(4'd9, 32'hABCD_0000, 32'hFFFF_FFE4, 32'h0ABC_D000, "R8");
        check32(4'd8, 32'h8000_0000, 32'h8000_0021, 32'hC000_0000, "R8");
        // R9 pass-through
        check32(4'd10, 32'h1111_2222, 32'hDEAD_BEEF, 32'hDEAD_BEEF, "R9");
        // R10 undefined codes
        for (int c = 11; c < 16; c++)
            check32(4'(c), 32'hFFFF_FFFF, 32'hA5A5_5A5A, 32'h0, "R10");

        // near-exhaustive sweep of the 8-bit instance
        for (int op = 0; op < 16; op++)
            for (int a = 0; a < 256; a++)
                for (int bi = 0; bi < 16; bi++)
                    check8(4'(op), 8'(a), 8'(bi * 37 + 3));

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule